// File: doc/BRIEF.md
# Serial-Clock Idle Sleep and Wake Controller

This block decides the power mode of a serial-output converter from the serial clock pin alone. A free-running timebase clock samples the pin through a synchroniser and times how long the pin has held its current level. If the pin stays high long enough, the block goes to sleep. If, while asleep, the pin stays low long enough, the block wakes. Any change of the pin level starts the timing over.

On waking, the block asserts a reset to the converter's internal logic and digital filter for a fixed number of timebase cycles. It also raises a flag that marks the next few completed conversions as not fully settled. The converter reports each completed conversion with a one-cycle pulse, and the flag drops once enough of those pulses have arrived outside the reset window.

The output enable of the serial data pin comes straight from the active-low chip select, whether the block is asleep or not. The integrator sets the sleep threshold in timebase ticks. It should fall between the earliest allowed sleep entry (200 µs of high clock) and the latest required one (2 ms). The wake threshold should cover at least 10 µs of low clock.

Top module: `sclk_idle_pm`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, the block is in normal mode: `sleep_o`, `logic_rst_o` and `unsettled_o` are all 0.
- R2: In normal mode, `sleep_o` rises at the (SLEEP_TICKS+3)-th rising clock edge, counting the first edge that samples `sclk_pin` high as edge 1, provided every edge up to edge SLEEP_TICKS samples it high. A high run of fewer than SLEEP_TICKS samples never causes sleep, and one low sample starts the count over.
- R3: In sleep, `sleep_o` falls at the (WAKE_TICKS+3)-th edge, counting the first edge that samples `sclk_pin` low as edge 1, provided WAKE_TICKS consecutive low samples occur. A shorter low run, or any length of high level, leaves the block asleep.
- R4: `logic_rst_o` rises in the same cycle that `sleep_o` falls. It stays high for exactly RST_CYCLES cycles, and `sleep_o` stays 0 throughout that time.
- R5: `unsettled_o` rises in the same cycle that `sleep_o` falls. This holds even when a `conv_done` pulse is sampled in that same cycle.
- R6: After the reset window, `unsettled_o` falls at the clock edge that samples the UNSETTLED_CONV-th counted `conv_done` pulse (default 3). Further pulses leave it at 0.
- R7: A `conv_done` pulse sampled while `logic_rst_o` is high, while asleep, or in the wake cycle itself does not count toward R6.
- R8: `sdo_oe_o` is 1 exactly when `csn_pin` is 0, without any clock delay, in both normal mode and sleep.
- R9: In normal mode, a low `sclk_pin` of any length changes none of `sleep_o`, `logic_rst_o` or `unsettled_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running timebase clock |
| rst_n | input | 1 | Active-low power-up reset, asynchronous |
| sclk_pin | input | 1 | Serial clock pin, asynchronous to `clk` |
| csn_pin | input | 1 | Chip select pin, active low |
| conv_done | input | 1 | One-cycle pulse per completed conversion |
| sleep_o | output | 1 | 1 while in sleep mode |
| logic_rst_o | output | 1 | Reset to internal logic and filter after wake |
| unsettled_o | output | 1 | Marks current conversions as not fully settled |
| sdo_oe_o | output | 1 | Output enable of the serial data pin driver |

## Verification
The wake transition loads the unsettled count, and a conversion pulse would decrement that same count. These two updates can land on the same clock edge. The bench provokes this by driving `conv_done` high exactly for the edge at which `sleep_o` falls, and then a second pulse inside the reset window. Load must win and neither pulse may count, so the bench expects `unsettled_o` to stay high through two later pulses and to drop only on the third.

// File: rtl/sclk_idle_pm_pkg.sv
package sclk_idle_pm_pkg;

  typedef enum logic [1:0] {
    PM_NORMAL = 2'd0,
    PM_SLEEP  = 2'd1,
    PM_WAKE   = 2'd2
  } pm_state_e;

  // True once a level seen with run count 'run' has been sampled 'ticks' times.
  function automatic logic held_for(input logic [31:0] run, input logic [31:0] ticks);
    return (run + 32'd1) >= ticks;
  endfunction

  // Next value of a down counter that stops at zero.
  function automatic logic [31:0] dec_floor(input logic [31:0] v);
    return (v == 32'd0) ? 32'd0 : v - 32'd1;
  endfunction

endpackage

// File: rtl/sclk_pin_sync.sv
module sclk_pin_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic lvl_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= {sh_q[STAGES-2:0], pin_i};
  end

  assign lvl_o = sh_q[STAGES-1];
endmodule

// File: rtl/level_run_timer.sv
module level_run_timer #(
  parameter int unsigned LIMIT = 40,
  localparam int unsigned W    = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lvl_i,
  output logic         lvl_o,
  output logic [W-1:0] run_o
);
  localparam logic [W-1:0] LIM_W = W'(LIMIT);

  logic         lvl_q;
  logic [W-1:0] run_q;
  logic         lvl_change;

  assign lvl_change = (lvl_i != lvl_q);

  // Any level change restarts the run; otherwise count up and saturate.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      run_q <= '0;
    end else if (lvl_change) begin
      lvl_q <= lvl_i;
      run_q <= '0;
    end else if (run_q != LIM_W) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign lvl_o = lvl_q;
  assign run_o = run_q;
endmodule

// File: rtl/pm_mode_fsm.sv
module pm_mode_fsm
  import sclk_idle_pm_pkg::*;
#(
  parameter int unsigned SLEEP_TICKS = 40,
  parameter int unsigned WAKE_TICKS  = 6,
  parameter int unsigned RST_CYCLES  = 3,
  parameter int unsigned RUN_W       = 6,
  localparam int unsigned RCW        = $clog2(RST_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_i,
  input  logic [RUN_W-1:0] run_i,
  output logic             wake_evt_o,
  output logic             sleep_o,
  output logic             logic_rst_o
);
  localparam logic [RCW-1:0] RC_LAST = RCW'(RST_CYCLES - 1);

  pm_state_e      state_q, state_d;
  logic [RCW-1:0] rc_q;
  logic           high_long, low_long;

  assign high_long = lvl_i  && held_for(32'(run_i), SLEEP_TICKS);
  assign low_long  = !lvl_i && held_for(32'(run_i), WAKE_TICKS);

  always_comb begin
    state_d    = state_q;
    wake_evt_o = 1'b0;
    unique case (state_q)
      PM_NORMAL: if (high_long) state_d = PM_SLEEP;
      PM_SLEEP: begin
        if (low_long) begin
          state_d    = PM_WAKE;
          wake_evt_o = 1'b1;
        end
      end
      PM_WAKE:   if (rc_q == RC_LAST) state_d = PM_NORMAL;
      default:   state_d = PM_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PM_NORMAL;
      rc_q    <= '0;
    end else begin
      state_q <= state_d;
      rc_q    <= (state_q == PM_WAKE) ? rc_q + 1'b1 : '0;
    end
  end

  assign sleep_o     = (state_q == PM_SLEEP);
  assign logic_rst_o = (state_q == PM_WAKE);
endmodule

// File: rtl/settle_window.sv
module settle_window
  import sclk_idle_pm_pkg::*;
#(
  parameter int unsigned N_UNSETTLED = 3,
  localparam int unsigned CW         = $clog2(N_UNSETTLED + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_evt_i,
  input  logic hold_i,
  input  logic conv_done_i,
  output logic unsettled_o
);
  logic [CW-1:0] left_q;
  logic [31:0]   left_dec;
  logic          count_evt;

  // A conversion counts only outside reset/sleep; a wake load wins over it.
  assign count_evt = conv_done_i && !hold_i;
  assign left_dec  = dec_floor(32'(left_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          left_q <= '0;
    else if (wake_evt_i) left_q <= CW'(N_UNSETTLED);
    else if (count_evt)  left_q <= left_dec[CW-1:0];
  end

  assign unsettled_o = (left_q != '0);
endmodule

// File: rtl/sclk_idle_pm.sv
module sclk_idle_pm #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SLEEP_TICKS = 40,
  parameter int unsigned WAKE_TICKS  = 6,
  parameter int unsigned RST_CYCLES  = 3,
  parameter int unsigned N_UNSETTLED = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_pin,
  input  logic csn_pin,
  input  logic conv_done,
  output logic sleep_o,
  output logic logic_rst_o,
  output logic unsettled_o,
  output logic sdo_oe_o
);
  localparam int unsigned RUN_LIM = (SLEEP_TICKS > WAKE_TICKS) ? SLEEP_TICKS : WAKE_TICKS;
  localparam int unsigned RUN_W   = $clog2(RUN_LIM + 1);

  logic             sclk_sync;
  logic             sclk_lvl;
  logic [RUN_W-1:0] run_cnt;
  logic             wake_evt;
  logic             settle_hold;

  sclk_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(sclk_pin), .lvl_o(sclk_sync)
  );

  level_run_timer #(.LIMIT(RUN_LIM)) u_timer (
    .clk(clk), .rst_n(rst_n), .lvl_i(sclk_sync), .lvl_o(sclk_lvl), .run_o(run_cnt)
  );

  pm_mode_fsm #(
    .SLEEP_TICKS(SLEEP_TICKS), .WAKE_TICKS(WAKE_TICKS),
    .RST_CYCLES(RST_CYCLES), .RUN_W(RUN_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .lvl_i(sclk_lvl), .run_i(run_cnt),
    .wake_evt_o(wake_evt), .sleep_o(sleep_o), .logic_rst_o(logic_rst_o)
  );

  assign settle_hold = logic_rst_o || sleep_o;

  settle_window #(.N_UNSETTLED(N_UNSETTLED)) u_settle (
    .clk(clk), .rst_n(rst_n), .wake_evt_i(wake_evt), .hold_i(settle_hold),
    .conv_done_i(conv_done), .unsettled_o(unsettled_o)
  );

  // Pad enable follows chip select directly, in every power mode.
  assign sdo_oe_o = !csn_pin;
endmodule

// File: rtl/sclk_idle_pm_chk.sv
module sclk_idle_pm_chk #(
  parameter int unsigned SLEEP_TICKS = 40,
  parameter int unsigned RST_CYCLES  = 3,
  parameter int unsigned CW          = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sclk_lvl,
  input logic [CW-1:0] run_cnt,
  input logic          wake_evt,
  input logic          conv_done,
  input logic          csn_pin,
  input logic          sleep_o,
  input logic          logic_rst_o,
  input logic          unsettled_o,
  input logic          sdo_oe_o
);
  int unsigned rst_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rst_len <= 0;
    else if (logic_rst_o) rst_len <= rst_len + 1;
    else                  rst_len <= 0;
  end

  AST_SLEEP_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_o) |-> ($past(sclk_lvl) && (32'($past(run_cnt)) + 32'd1 >= SLEEP_TICKS))); // R2
  AST_WAKE_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_o) |-> !$past(sclk_lvl)); // R3
  AST_WAKE_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_o) |-> logic_rst_o); // R4
  AST_RST_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    logic_rst_o |-> !sleep_o); // R4
  AST_RST_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(logic_rst_o) |-> (rst_len == RST_CYCLES)); // R4
  AST_WAKE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> unsettled_o); // R5
  AST_SETTLE_BY_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(unsettled_o) |-> ($past(conv_done) && !$past(logic_rst_o))); // R7
  AST_OE_IN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_o && !csn_pin) |-> sdo_oe_o); // R8
  AST_OE_OFF_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    csn_pin |-> !sdo_oe_o); // R8
endmodule

bind sclk_idle_pm sclk_idle_pm_chk #(
  .SLEEP_TICKS(SLEEP_TICKS), .RST_CYCLES(RST_CYCLES), .CW(RUN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_lvl(sclk_lvl), .run_cnt(run_cnt),
  .wake_evt(wake_evt), .conv_done(conv_done), .csn_pin(csn_pin),
  .sleep_o(sleep_o), .logic_rst_o(logic_rst_o), .unsettled_o(unsettled_o),
  .sdo_oe_o(sdo_oe_o)
);

// File: tb/sclk_idle_pm_bench.sv
module sclk_idle_pm_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SLP = 40;
  localparam int WAK = 6;
  localparam int RSTC = 3;
  localparam int NUN = 3;
  localparam int NVEC = 6;
  // {expected sleep, high samples}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 16'd1}, {1'b0, 16'd10}, {1'b0, 16'd39},
    {1'b1, 16'd40}, {1'b1, 16'd41}, {1'b1, 16'd60}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk_pin = 1'b0;
  logic csn_pin = 1'b1;
  logic conv_done = 1'b0;
  logic sleep_o, logic_rst_o, unsettled_o, sdo_oe_o;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sclk_idle_pm #(
    .SLEEP_TICKS(SLP), .WAKE_TICKS(WAK), .RST_CYCLES(RSTC), .N_UNSETTLED(NUN)
  ) u_sclk_idle_pm (
    .clk(clk), .rst_n(rst_n), .sclk_pin(sclk_pin), .csn_pin(csn_pin),
    .conv_done(conv_done), .sleep_o(sleep_o), .logic_rst_o(logic_rst_o),
    .unsettled_o(unsettled_o), .sdo_oe_o(sdo_oe_o)
  );

  task automatic chk(input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  task automatic hold_high(input int n);
    @(negedge clk) sclk_pin = 1'b1;
    repeat (n) @(negedge clk);
    sclk_pin = 1'b0;
  endtask

  task automatic conv_pulse();
    @(negedge clk) conv_done = 1'b1;
    @(negedge clk) conv_done = 1'b0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 sleep in reset", sleep_o, 1'b0);
    chk("R1 logic_rst in reset", logic_rst_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sleep after reset", sleep_o, 1'b0);
    chk("R1 unsettled after reset", unsettled_o, 1'b0);

    repeat (60) @(negedge clk);
    chk("R9 long low in normal: sleep", sleep_o, 1'b0);
    chk("R9 long low in normal: logic_rst", logic_rst_o, 1'b0);
    chk("R9 long low in normal: unsettled", unsettled_o, 1'b0);

    csn_pin = 1'b1; #1;
    chk("R8 deselected awake", sdo_oe_o, 1'b0);
    csn_pin = 1'b0; #1;
    chk("R8 selected awake", sdo_oe_o, 1'b1);
    csn_pin = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      hold_high(int'(VEC[i][15:0]));
      repeat (4) @(negedge clk);
      chk($sformatf("R2 table entry %0d high=%0d", i, VEC[i][15:0]), sleep_o, VEC[i][16]);
      repeat (WAK + RSTC + 12) @(negedge clk);
      repeat (NUN) conv_pulse();
    end

    // R2 restart: one low sample between two sub-threshold high runs
    hold_high(SLP - 5);
    hold_high(SLP - 5);
    repeat (6) @(negedge clk);
    chk("R2 low sample restarts count", sleep_o, 1'b0);

    // R2 exact entry edge
    @(negedge clk) sclk_pin = 1'b1;
    repeat (SLP + 2) @(negedge clk);
    chk("R2 one edge before entry", sleep_o, 1'b0);
    @(negedge clk);
    chk("R2 entry edge", sleep_o, 1'b1);

    csn_pin = 1'b0; #1;
    chk("R8 selected asleep", sdo_oe_o, 1'b1);
    csn_pin = 1'b1; #1;
    chk("R8 deselected asleep", sdo_oe_o, 1'b0);

    repeat (50) @(negedge clk);
    chk("R3 high in sleep keeps sleeping", sleep_o, 1'b1);

    // R3 short low run
    sclk_pin = 1'b0;
    repeat (WAK - 1) @(negedge clk);
    sclk_pin = 1'b1;
    repeat (12) @(negedge clk);
    chk("R3 short low keeps sleeping", sleep_o, 1'b1);

    // R3 exact wake edge, with a conversion pulse on the same edge
    sclk_pin = 1'b0;
    repeat (WAK + 2) @(negedge clk);
    chk("R3 one edge before wake", sleep_o, 1'b1);
    conv_done = 1'b1;
    @(negedge clk) conv_done = 1'b0;
    chk("R3 wake edge", sleep_o, 1'b0);
    chk("R4 reset with wake", logic_rst_o, 1'b1);
    chk("R5 unsettled with wake", unsettled_o, 1'b1);

    // R7 pulse inside reset window
    conv_done = 1'b1;
    @(negedge clk) conv_done = 1'b0;
    chk("R4 reset second cycle", logic_rst_o, 1'b1);
    @(negedge clk);
    chk("R4 reset third cycle", logic_rst_o, 1'b1);
    @(negedge clk);
    chk("R4 reset ends", logic_rst_o, 1'b0);
    chk("R4 awake after reset", sleep_o, 0);
    chk("R7 pulses in wake/reset not counted", unsettled_o, 1'b1);

    conv_pulse();
    chk("R6 after first conversion", unsettled_o, 1'b1);
    conv_pulse();
    chk("R6 R7 after second conversion", unsettled_o, 1'b1);
    conv_pulse();
    chk("R6 settled after third conversion", unsettled_o, 1'b0);
    conv_pulse();
    chk("R6 extra conversion keeps settled", unsettled_o, 1'b0);

    finish_run();
  end
endmodule